// File: doc/BRIEF.md
# DDS Phase Generator with Offset and Buffered Update

This block is the phase source of a direct digital synthesizer. On every system clock it adds a 32-bit unsigned frequency tuning word to a 32-bit phase accumulator. The accumulator wraps modulo 2^32. A 14-bit phase offset is then added to the upper 14 bits of the accumulated phase, and the result is cut down to a 19-bit phase word for a cosine lookup stage further down the chain.

The tuning word, the offset and two clear-control bits are written into shadow buffers, and these buffers have no effect on the output. The block divides the system clock by four to make a sync clock, which is driven out so that external logic can align with it. An update strobe is captured only on the rising edge of that sync clock. One system clock after the capture, all buffered values become active together.

There are two ways to clear the accumulator. A held clear keeps it at zero for as long as the active bit stays set. An automatic clear zeroes it once on each transfer whose control word has that bit set, and counting then resumes.

Top module: `dds_phase_core`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it goes high, phase_o is 0 and sync_clk_o is 0. Reset also clears every buffered and active register and the accumulator.
- R2: On each clock edge where no clear applies, the accumulator takes the value accumulator + active tuning word, modulo 2^32.
- R3: phase_o[18:5] = (accumulator[31:18] + active offset) mod 2^14, and phase_o[4:0] = accumulator[17:13].
- R4: sync_clk_o repeats a pattern of 2 cycles low and then 2 cycles high. It first rises at the second clock edge after reset is released.
- R5: A write into the tuning, offset or control buffer (ftw_we_i, pow_we_i, ctl_we_i) has no effect on phase_o until a transfer takes place.
- R6: update_i is sampled only at the clock edge where sync_clk_o rises. A high level of update_i at any other edge is ignored.
- R7: A sampled update causes a transfer at the next clock edge: the active tuning word, offset and control take the buffered values. The transfer edge itself still adds the old tuning word.
- R8: While the active hold-clear bit is set, the accumulator is 0 at every edge, so phase_o = {active offset, 5'b0}.
- R9: At a transfer edge where the buffered auto-clear bit is 1, the accumulator becomes 0. It then accumulates again from the next edge on.
- R10: A tuning word of 0x80000000 with offset 0, started from a cleared accumulator, makes phase_o alternate between 0x00000 and 0x40000 on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ftw_we_i | input | 1 | Writes ftw_i into the tuning-word buffer |
| ftw_i | input | 32 | Frequency tuning word, unsigned |
| pow_we_i | input | 1 | Writes pow_i into the offset buffer |
| pow_i | input | 14 | Phase offset word |
| ctl_we_i | input | 1 | Writes the two clear bits into the control buffer |
| hold_clr_i | input | 1 | Hold-clear control bit |
| auto_clr_i | input | 1 | Auto-clear-on-transfer control bit |
| update_i | input | 1 | Update strobe, sampled on the rising sync clock edge |
| sync_clk_o | output | 1 | System clock divided by 4 |
| phase_o | output | 19 | Phase word for the cosine stage |

## Verification
Some rules are checked by assertions at every clock. These cover the 2-high/2-low shape of the sync clock, the update of the accumulator by the active tuning word, and the zero accumulator under hold clear and after an auto-clear transfer. They also check that active registers change only on transfer edges, and that those edges fall only in the cycle after a rising sync clock. Other behaviours need driven scenarios and a reference model. These include ignoring update pulses at the wrong phase, having no effect from buffer writes before an update, mapping the offset and truncation onto phase_o, wrapping on overflow, and the Nyquist alternation.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef struct packed {
    logic hold_clr;
    logic auto_clr;
  } dds_ctl_t;
endpackage

// File: rtl/dds_sync_div.sv
module dds_sync_div #(
  parameter int DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic update_i,
  output logic sync_clk_o,
  output logic xfer_o
);
  localparam logic [DIV_W-1:0] SampleCnt = {1'b0, {(DIV_W-1){1'b1}}};

  logic [DIV_W-1:0] cnt_q;
  logic             xfer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      xfer_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      // capture on the edge where the divided clock rises
      xfer_q <= (cnt_q == SampleCnt) && update_i;
    end
  end

  assign sync_clk_o = cnt_q[DIV_W-1];
  assign xfer_o     = xfer_q;
endmodule

// File: rtl/dds_regbank.sv
module dds_regbank
  import dds_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int POW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ftw_we_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic             pow_we_i,
  input  logic [POW_W-1:0] pow_i,
  input  logic             ctl_we_i,
  input  dds_ctl_t         ctl_i,
  input  logic             xfer_i,
  output logic [ACC_W-1:0] ftw_act_o,
  output logic [POW_W-1:0] pow_act_o,
  output dds_ctl_t         ctl_act_o,
  output dds_ctl_t         ctl_buf_o
);
  logic [ACC_W-1:0] ftw_buf_q, ftw_act_q;
  logic [POW_W-1:0] pow_buf_q, pow_act_q;
  dds_ctl_t         ctl_buf_q, ctl_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_buf_q <= '0;
      pow_buf_q <= '0;
      ctl_buf_q <= '0;
    end else begin
      if (ftw_we_i) ftw_buf_q <= ftw_i;
      if (pow_we_i) pow_buf_q <= pow_i;
      if (ctl_we_i) ctl_buf_q <= ctl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_act_q <= '0;
      pow_act_q <= '0;
      ctl_act_q <= '0;
    end else if (xfer_i) begin
      ftw_act_q <= ftw_buf_q;
      pow_act_q <= pow_buf_q;
      ctl_act_q <= ctl_buf_q;
    end
  end

  assign ftw_act_o = ftw_act_q;
  assign pow_act_o = pow_act_q;
  assign ctl_act_o = ctl_act_q;
  assign ctl_buf_o = ctl_buf_q;
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int POW_W = 14,
  parameter int PH_W  = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [POW_W-1:0] pow_i,
  input  logic             hold_clr_i,
  input  logic             pulse_clr_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [PH_W-1:0]  phase_o
);
  localparam int LoW = PH_W - POW_W;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [POW_W-1:0] top_sum;

  always_comb begin
    if (hold_clr_i || pulse_clr_i) acc_d = '0;
    else                           acc_d = acc_q + ftw_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign top_sum = acc_q[ACC_W-1 -: POW_W] + pow_i;

  generate
    if (LoW > 0) begin : g_fine
      assign phase_o = {top_sum, acc_q[ACC_W-POW_W-1 -: LoW]};
    end else begin : g_coarse
      assign phase_o = top_sum[POW_W-1 -: PH_W];
    end
  endgenerate

  assign acc_o = acc_q;
endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int POW_W = 14,
  parameter int PH_W  = 19,
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ftw_we_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic             pow_we_i,
  input  logic [POW_W-1:0] pow_i,
  input  logic             ctl_we_i,
  input  logic             hold_clr_i,
  input  logic             auto_clr_i,
  input  logic             update_i,
  output logic             sync_clk_o,
  output logic [PH_W-1:0]  phase_o
);
  logic             xfer;
  logic [ACC_W-1:0] ftw_act;
  logic [POW_W-1:0] pow_act;
  logic [ACC_W-1:0] acc;
  dds_ctl_t         ctl_act, ctl_buf, ctl_in;
  logic             hold_act, auto_buf, pulse_clr;

  assign ctl_in = '{hold_clr: hold_clr_i, auto_clr: auto_clr_i};

  dds_sync_div #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .update_i  (update_i),
    .sync_clk_o(sync_clk_o),
    .xfer_o    (xfer)
  );

  dds_regbank #(.ACC_W(ACC_W), .POW_W(POW_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ftw_we_i (ftw_we_i),
    .ftw_i    (ftw_i),
    .pow_we_i (pow_we_i),
    .pow_i    (pow_i),
    .ctl_we_i (ctl_we_i),
    .ctl_i    (ctl_in),
    .xfer_i   (xfer),
    .ftw_act_o(ftw_act),
    .pow_act_o(pow_act),
    .ctl_act_o(ctl_act),
    .ctl_buf_o(ctl_buf)
  );

  assign hold_act  = ctl_act.hold_clr;
  assign auto_buf  = ctl_buf.auto_clr;
  // one-shot clear uses the control word being transferred
  assign pulse_clr = xfer && auto_buf;

  dds_phase_acc #(.ACC_W(ACC_W), .POW_W(POW_W), .PH_W(PH_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ftw_i      (ftw_act),
    .pow_i      (pow_act),
    .hold_clr_i (hold_act),
    .pulse_clr_i(pulse_clr),
    .acc_o      (acc),
    .phase_o    (phase_o)
  );
endmodule

// File: rtl/dds_phase_core_chk.sv
module dds_phase_core_chk #(
  parameter int ACC_W = 32,
  parameter int POW_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_clk_i,
  input logic             xfer_i,
  input logic             hold_i,
  input logic             auto_buf_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [ACC_W-1:0] ftw_act_i,
  input logic [POW_W-1:0] pow_act_i
);
  assert_sync_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_clk_i) |=> (sync_clk_i ##1 !sync_clk_i));

  assert_sync_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_clk_i) |=> (!sync_clk_i ##1 sync_clk_i));

  assert_accumulate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !(xfer_i && auto_buf_i)) |=>
      acc_i == ACC_W'($past(acc_i) + $past(ftw_act_i)));

  assert_hold_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> acc_i == '0);

  assert_auto_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && auto_buf_i) |=> acc_i == '0);

  assert_xfer_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |-> (sync_clk_i && !$past(sync_clk_i)));

  assert_active_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> ($stable(ftw_act_i) && $stable(pow_act_i)));
endmodule

bind dds_phase_core dds_phase_core_chk #(.ACC_W(ACC_W), .POW_W(POW_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_clk_i(sync_clk_o),
  .xfer_i    (xfer),
  .hold_i    (hold_act),
  .auto_buf_i(auto_buf),
  .acc_i     (acc),
  .ftw_act_i (ftw_act),
  .pow_act_i (pow_act)
);

// File: tb/dds_phase_core_bench.sv
module dds_phase_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ftw_we = 1'b0, pow_we = 1'b0, ctl_we = 1'b0;
  logic [31:0] ftw = '0;
  logic [13:0] pow = '0;
  logic        hold_clr = 1'b0, auto_clr = 1'b0, update = 1'b0;
  logic        sync_clk;
  logic [18:0] phase;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_phase_core u_dds_phase_core (
    .clk_i(clk), .rst_ni(rst_n),
    .ftw_we_i(ftw_we), .ftw_i(ftw),
    .pow_we_i(pow_we), .pow_i(pow),
    .ctl_we_i(ctl_we), .hold_clr_i(hold_clr), .auto_clr_i(auto_clr),
    .update_i(update), .sync_clk_o(sync_clk), .phase_o(phase)
  );

  // behavioural reference
  int unsigned m_acc, m_ftw_b, m_ftw_a;
  int unsigned m_pow_b, m_pow_a;
  bit m_hold_b, m_hold_a, m_auto_b, m_pend;
  int m_cyc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= 0; m_ftw_b <= 0; m_ftw_a <= 0; m_pow_b <= 0; m_pow_a <= 0;
      m_hold_b <= 0; m_hold_a <= 0; m_auto_b <= 0; m_pend <= 0; m_cyc <= 0;
    end else begin
      if (m_hold_a || (m_pend && m_auto_b)) m_acc <= 0;
      else m_acc <= m_acc + m_ftw_a;
      if (m_pend) begin
        m_ftw_a <= m_ftw_b; m_pow_a <= m_pow_b; m_hold_a <= m_hold_b;
      end
      if (ftw_we) m_ftw_b <= ftw;
      if (pow_we) m_pow_b <= 32'(pow);
      if (ctl_we) begin m_hold_b <= hold_clr; m_auto_b <= auto_clr; end
      m_pend <= ((m_cyc % 4) == 1) && update;
      m_cyc  <= m_cyc + 1;
    end
  end

  function automatic int unsigned exp_phase();
    int unsigned hi;
    hi = ((m_acc >> 18) + m_pow_a) & 32'h3fff;
    return (hi << 5) | ((m_acc >> 13) & 32'h1f);
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur_req, " R3 phase"}, 32'(phase), exp_phase());
      check("R4 sync", 32'(sync_clk), ((m_cyc % 4) >= 2) ? 1 : 0);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] f, input logic [13:0] p, input bit h, input bit a);
    ftw = f; pow = p; hold_clr = h; auto_clr = a;
    ftw_we = 1; pow_we = 1; ctl_we = 1;
    @(negedge clk);
    ftw_we = 0; pow_we = 0; ctl_we = 0;
  endtask

  task automatic commit();
    update = 1;
    cycles(4);
    update = 0;
    cycles(2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic prev;
    cur_req = "R1";
    cycles(3);
    check("R1 reset phase", 32'(phase), 0);
    check("R1 reset sync", 32'(sync_clk), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 first cycle phase", 32'(phase), 0);

    cur_req = "R5";
    load(32'h0100_0000, 14'h0123, 0, 0);
    cycles(8);
    check("R5 buffered write no effect", 32'(phase), 0);

    cur_req = "R6";
    while ((m_cyc % 4) != 2) @(negedge clk);
    update = 1;
    @(negedge clk);
    update = 0;
    cycles(8);
    check("R6 off-phase update ignored", 32'(phase), 0);

    cur_req = "R7";
    commit();
    cycles(1);
    check("R7 transfer took effect", 32'(phase != 0), 1);

    cur_req = "R2";
    load(32'h1234_5679, 14'h2abc, 0, 0);
    commit();
    cycles(40);
    load(32'hF000_0000, 14'h3fff, 0, 0);
    commit();
    cycles(30);

    cur_req = "R8";
    load(32'h0765_4321, 14'h1555, 1, 0);
    commit();
    cycles(4);
    for (int i = 0; i < 4; i++) begin
      check("R8 hold clear", 32'(phase), 32'h1555 << 5);
      @(negedge clk);
    end

    cur_req = "R10";
    load(32'h8000_0000, 14'h0000, 0, 1);
    commit();
    cycles(3);
    prev = phase[18];
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R10 nyquist low bits", 32'(phase[17:0]), 0);
      check("R10 nyquist toggle", 32'(phase[18]), 32'(!prev));
      prev = phase[18];
    end

    cur_req = "R9";
    load(32'h0001_0000, 14'h0004, 0, 1);
    update = 1;
    cycles(4);
    update = 0;
    cycles(20);
    load(32'h0002_0000, 14'h0004, 0, 1);
    commit();
    cycles(20);

    finish_run();
  end
endmodule